// File: doc/BRIEF.md
# Alternating-Row DRAM Hammer Sequencer

This block drives the read command port of a memory controller so that two addresses in one DRAM bank are read in turn, over and over, for a programmed number of toggles. Both addresses share a bank and a column and differ only in the row. Each read therefore lands on a row other than the one left open, and the controller has to close that row and activate the other one. A single-row mode reads the same row every time. It relies on the controller closing the row after each access, for example with auto-precharge on every read. Typical row pairs are neighbours such as (2n, 2n+1), or rows two apart such as (n, n+2), which leave one victim row between them. A column near the middle of the row, such as 512, is a common choice.

Software sets the two rows, the bank, the column, the toggle count and the mode, then pulses start. While the run is active the block holds a request to the controller to suspend refresh. It does not wait for each read's data before issuing the next read. The number of reads in flight is capped by a parameter. The run ends only after every issued read has returned its data. At that point the refresh request drops and a sticky done flag rises, so a checking pass can follow with refresh back on.

Top module: `hammer_seq`

## Requirements
- R1: During and just after reset, busy, done, refresh_off and rd_valid are low and toggles is zero.
- R2: A start pulse seen while idle makes busy and refresh_off high one cycle later, with done low and toggles zero. refresh_off equals busy at all times.
- R3: rd_addr is formed from three fields with no other bit mapping. The row is in the top ROW_W bits, the bank in the next BANK_W bits, and the column in the low COL_W bits. The defaults are 14, 3 and 10, so row 6, bank 5, column 512 gives address 54784.
- R4: When cfg_single is 0, accepted reads alternate between the two rows. The first accepted read of a run goes to cfg_row_a, the second to cfg_row_b, and so on. All reads use the latched bank and column.
- R5: When cfg_single is 1, every read of the run goes to cfg_row_a.
- R6: toggles rises by one only for a read that is accepted, meaning rd_valid and rd_ready are both high. While a read is stalled, rd_valid stays high and rd_addr and toggles hold their values.
- R7: The block never has more than MAX_OUT reads accepted but without returned data (one rdata_valid pulse per read). While credit remains it issues the next read without waiting for data.
- R8: A run issues exactly cfg_count accepted reads. Consider the first cycle in which all of them have been accepted and all their data has returned. At the next edge, busy and refresh_off fall and done rises together.
- R9: With a count of zero, the run issues no read. It finishes one cycle after it becomes busy.
- R10: A start pulse while busy has no effect. The configuration, the count and the end of the run are unchanged.
- R11: done stays high until the next accepted start, which clears it one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_row_a | input | ROW_W | First aggressor row |
| cfg_row_b | input | ROW_W | Second aggressor row |
| cfg_bank | input | BANK_W | Bank holding both rows |
| cfg_col | input | COL_W | Column used by every read |
| cfg_count | input | CNT_W | Number of toggles for the run |
| cfg_single | input | 1 | 1: re-read row A only; 0: alternate A and B |
| start | input | 1 | Start pulse, latches the configuration when idle |
| busy | output | 1 | Run in progress (issuing or draining) |
| done | output | 1 | Sticky completion flag |
| toggles | output | CNT_W | Accepted reads in the current or last run |
| refresh_off | output | 1 | Request to suspend refresh |
| rd_valid | output | 1 | Read command valid |
| rd_ready | input | 1 | Controller accepts the read command |
| rd_addr | output | ROW_W+BANK_W+COL_W | Flat read address |
| rdata_valid | input | 1 | One read's data has returned |

## Verification
The bench looks for runs that end while reads are still in flight. A design with that fault would drop refresh_off and raise done before the last data returns. The bench holds back returned data to show that issue stops at exactly MAX_OUT outstanding reads; a design that counted wrongly would overrun the controller or stall one read early. It stalls rd_ready for several cycles. A design that counted a toggle on valid alone, or flipped rows during a stall, would then skip a row or overshoot the count. It also fires start in the middle of a run and uses a count of zero. A design that reloaded its configuration, or waited for a read that never comes, would hang or end at the wrong toggle count.

// File: rtl/hammer_pkg.sv
package hammer_pkg;

  // Sequencer phases: idle, issuing reads, waiting for the last data to return.
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_RUN   = 2'd1,
    HS_DRAIN = 2'd2
  } hs_state_e;

  // Bits needed to hold the values 0..n.
  function automatic int unsigned span_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/hammer_addr_map.sv
module hammer_addr_map #(
  parameter int unsigned ROW_W  = 14,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned COL_W  = 10
) (
  input  logic [ROW_W-1:0]               row,
  input  logic [BANK_W-1:0]              bank,
  input  logic [COL_W-1:0]               col,
  output logic [ROW_W+BANK_W+COL_W-1:0]  addr
);
  localparam int unsigned BANK_LSB = COL_W;
  localparam int unsigned ROW_LSB  = COL_W + BANK_W;
  localparam int unsigned ADDR_W   = ROW_W + BANK_W + COL_W;

  // Row above bank above column, each field placed as-is.
  always_comb begin
    addr = '0;
    addr[ADDR_W-1:ROW_LSB]   = row;
    addr[ROW_LSB-1:BANK_LSB] = bank;
    addr[BANK_LSB-1:0]       = col;
  end
endmodule

// File: rtl/hammer_credit.sv
module hammer_credit
  import hammer_pkg::*;
#(
  parameter int unsigned MAX_OUT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic give,
  output logic avail,
  output logic idle
);
  localparam int unsigned CW = span_bits(MAX_OUT);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    unique case ({take, give})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign avail = (cnt_q < CW'(MAX_OUT));
  assign idle  = (cnt_q == '0);
endmodule

// File: rtl/hammer_ctrl.sv
module hammer_ctrl
  import hammer_pkg::*;
#(
  parameter int unsigned ROW_W  = 14,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ROW_W-1:0]  cfg_row_a,
  input  logic [ROW_W-1:0]  cfg_row_b,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [COL_W-1:0]  cfg_col,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_single,
  input  logic              accept,
  input  logic              credit_ok,
  input  logic              drained,
  output logic              issue_ok,
  output logic [ROW_W-1:0]  cur_row,
  output logic [BANK_W-1:0] cur_bank,
  output logic [COL_W-1:0]  cur_col,
  output logic              busy,
  output logic              done,
  output logic              refresh_off,
  output logic [CNT_W-1:0]  count
);
  hs_state_e state_q, state_d;

  logic [ROW_W-1:0]  row_a_q, row_b_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic [CNT_W-1:0]  tgt_q, cnt_q, cnt_d;
  logic              single_q, sel_q, sel_d;
  logic              done_q, done_d, refr_q, refr_d;
  logic              load, finish, reached;

  assign reached = (cnt_q == tgt_q);

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    finish  = 1'b0;
    unique case (state_q)
      HS_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = HS_RUN;
        end
      end
      HS_RUN: begin
        if (reached) begin
          if (drained) begin
            finish  = 1'b1;
            state_d = HS_IDLE;
          end else begin
            state_d = HS_DRAIN;
          end
        end
      end
      HS_DRAIN: begin
        if (drained) begin
          finish  = 1'b1;
          state_d = HS_IDLE;
        end
      end
      default: state_d = HS_IDLE;
    endcase

    cnt_d  = cnt_q;
    sel_d  = sel_q;
    if (load) begin
      cnt_d = '0;
      sel_d = 1'b0;
    end else if (accept) begin
      cnt_d = cnt_q + CNT_W'(1);
      sel_d = single_q ? 1'b0 : ~sel_q;
    end

    done_d = done_q;
    refr_d = refr_q;
    if (load) begin
      done_d = 1'b0;
      refr_d = 1'b1;
    end else if (finish) begin
      done_d = 1'b1;
      refr_d = 1'b0;
    end
  end

  // Control registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      done_q  <= 1'b0;
      refr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sel_q   <= sel_d;
      done_q  <= done_d;
      refr_q  <= refr_d;
    end
  end

  // Configuration snapshot, enabled only on an accepted start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_a_q  <= '0;
      row_b_q  <= '0;
      bank_q   <= '0;
      col_q    <= '0;
      tgt_q    <= '0;
      single_q <= 1'b0;
    end else if (load) begin
      row_a_q  <= cfg_row_a;
      row_b_q  <= cfg_row_b;
      bank_q   <= cfg_bank;
      col_q    <= cfg_col;
      tgt_q    <= cfg_count;
      single_q <= cfg_single;
    end
  end

  assign issue_ok    = (state_q == HS_RUN) && !reached && credit_ok;
  assign cur_row     = sel_q ? row_b_q : row_a_q;
  assign cur_bank    = bank_q;
  assign cur_col     = col_q;
  assign busy        = (state_q != HS_IDLE);
  assign done        = done_q;
  assign refresh_off = refr_q;
  assign count       = cnt_q;
endmodule

// File: rtl/hammer_seq.sv
module hammer_seq #(
  parameter int unsigned ROW_W   = 14,
  parameter int unsigned BANK_W  = 3,
  parameter int unsigned COL_W   = 10,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned MAX_OUT = 4,
  localparam int unsigned ADDR_W = ROW_W + BANK_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  cfg_row_a,
  input  logic [ROW_W-1:0]  cfg_row_b,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [COL_W-1:0]  cfg_col,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_single,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  toggles,
  output logic              refresh_off,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rdata_valid
);
  // Reset asserts at once and releases on a clock edge, after two flops.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic              issue_ok, accept, credit_ok, drained;
  logic [ROW_W-1:0]  cur_row;
  logic [BANK_W-1:0] cur_bank;
  logic [COL_W-1:0]  cur_col;

  assign rd_valid = issue_ok;
  assign accept   = issue_ok && rd_ready;

  hammer_ctrl #(
    .ROW_W (ROW_W),
    .BANK_W(BANK_W),
    .COL_W (COL_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .cfg_row_a  (cfg_row_a),
    .cfg_row_b  (cfg_row_b),
    .cfg_bank   (cfg_bank),
    .cfg_col    (cfg_col),
    .cfg_count  (cfg_count),
    .cfg_single (cfg_single),
    .accept     (accept),
    .credit_ok  (credit_ok),
    .drained    (drained),
    .issue_ok   (issue_ok),
    .cur_row    (cur_row),
    .cur_bank   (cur_bank),
    .cur_col    (cur_col),
    .busy       (busy),
    .done       (done),
    .refresh_off(refresh_off),
    .count      (toggles)
  );

  hammer_credit #(
    .MAX_OUT(MAX_OUT)
  ) u_credit (
    .clk  (clk),
    .rst_n(rst_int_n),
    .take (accept),
    .give (rdata_valid),
    .avail(credit_ok),
    .idle (drained)
  );

  hammer_addr_map #(
    .ROW_W (ROW_W),
    .BANK_W(BANK_W),
    .COL_W (COL_W)
  ) u_addr (
    .row (cur_row),
    .bank(cur_bank),
    .col (cur_col),
    .addr(rd_addr)
  );
endmodule

// File: rtl/hammer_seq_chk.sv
module hammer_seq_chk #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned ADDR_W  = 27,
  parameter int unsigned MAX_OUT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [CNT_W-1:0]  toggles,
  input logic              refresh_off,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rdata_valid
);
  // Independent count of reads in flight, seen from the ports.
  int unsigned fly_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fly_q <= 0;
    end else begin
      if ((rd_valid && rd_ready) && !(rdata_valid && fly_q != 0))
        fly_q <= fly_q + 1;
      else if (!(rd_valid && rd_ready) && rdata_valid && fly_q != 0)
        fly_q <= fly_q - 1;
    end
  end

  assert_refresh_follows_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_off == busy);

  assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !done && toggles == '0));

  assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr) && $stable(toggles)));

  assert_count_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> (toggles == $past(toggles) + CNT_W'(1)));

  assert_flight_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fly_q <= MAX_OUT);

  assert_valid_within_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  assert_end_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && fly_q == 0));

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
endmodule

bind hammer_seq hammer_seq_chk #(
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W),
  .MAX_OUT(MAX_OUT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .toggles    (toggles),
  .refresh_off(refresh_off),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_addr    (rd_addr),
  .rdata_valid(rdata_valid)
);

// File: tb/hammer_seq_test.sv
`timescale 1ns/1ps
module hammer_seq_test;
  localparam int ROW_W   = 14;
  localparam int BANK_W  = 3;
  localparam int COL_W   = 10;
  localparam int CNT_W   = 32;
  localparam int MAX_OUT = 4;
  localparam int ADDR_W  = ROW_W + BANK_W + COL_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n, start, cfg_single, rd_ready, rdata_valid;
  logic [ROW_W-1:0]  cfg_row_a, cfg_row_b;
  logic [BANK_W-1:0] cfg_bank;
  logic [COL_W-1:0]  cfg_col;
  logic [CNT_W-1:0]  cfg_count;
  logic              busy, done, refresh_off, rd_valid;
  logic [CNT_W-1:0]  toggles;
  logic [ADDR_W-1:0] rd_addr;

  hammer_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_row_a(cfg_row_a), .cfg_row_b(cfg_row_b),
    .cfg_bank(cfg_bank), .cfg_col(cfg_col), .cfg_count(cfg_count),
    .cfg_single(cfg_single), .start(start), .busy(busy), .done(done),
    .toggles(toggles), .refresh_off(refresh_off), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rdata_valid(rdata_valid)
  );

  int    checks = 0;
  int    errors = 0;
  longint cyc = 0;
  bit    cmp_en = 1'b0;
  bit    finished = 1'b0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit     m_busy, m_done, m_sel, m_single;
  longint m_cnt, m_tgt;
  int     m_out, m_ra, m_rb, m_bank, m_col;

  function automatic bit exp_valid();
    return m_busy && (m_cnt < m_tgt) && (m_out < MAX_OUT);
  endfunction

  function automatic longint exp_addr();
    int row;
    row = (m_single || !m_sel) ? m_ra : m_rb;
    return (longint'(row) << (BANK_W + COL_W)) + (longint'(m_bank) << COL_W) + longint'(m_col);
  endfunction

  // ---------------- memory responder state ----------------
  longint due_q[$];
  bit     hold_ret;
  int     lat;
  int     ready_mode;
  logic [15:0] lfsr;

  always @(posedge clk) begin
    bit macc;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_sel = 0; m_single = 0;
      m_cnt = 0; m_tgt = 0; m_out = 0;
      m_ra = 0; m_rb = 0; m_bank = 0; m_col = 0;
      due_q.delete();
    end else begin
      if (rdata_valid && due_q.size() > 0) void'(due_q.pop_front());
      if (rd_valid && rd_ready) due_q.push_back(cyc + lat);
      macc = exp_valid() && rd_ready;
      if (!m_busy) begin
        if (start) begin
          m_ra = int'(cfg_row_a); m_rb = int'(cfg_row_b);
          m_bank = int'(cfg_bank); m_col = int'(cfg_col);
          m_tgt = longint'(cfg_count); m_single = cfg_single;
          m_busy = 1; m_done = 0; m_cnt = 0; m_sel = 0;
        end
      end else if (m_cnt == m_tgt && m_out == 0) begin
        m_busy = 0;
        m_done = 1;
      end else begin
        if (macc) begin
          m_cnt++;
          if (!m_single) m_sel = !m_sel;
        end
        m_out = m_out + int'(macc) - int'(rdata_valid);
      end
    end
    cyc++;
  end

  // Compare every cycle, then drive the responder for the next edge.
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk("R8",  "busy",        busy,        m_busy);
      chk("R11", "done",        done,        m_done);
      chk("R2",  "refresh_off", refresh_off, m_busy);
      chk("R7",  "rd_valid",    rd_valid,    exp_valid());
      if (exp_valid()) chk("R4", "rd_addr", longint'(rd_addr), exp_addr());
      chk("R6",  "toggles",     longint'(toggles), m_cnt);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ready_mode)
      0:       rd_ready = 1'b1;
      1:       rd_ready = lfsr[0] | lfsr[5];
      default: rd_ready = 1'b0;
    endcase
    rdata_valid = (due_q.size() > 0) && (due_q[0] <= cyc) && !hold_ret;
  end

  // ---------------- stimulus helpers ----------------
  task automatic setup(int ra, int rb, int bank, int col, longint cnt, bit single);
    @(negedge clk);
    cfg_row_a = ROW_W'(ra); cfg_row_b = ROW_W'(rb);
    cfg_bank = BANK_W'(bank); cfg_col = COL_W'(col);
    cfg_count = CNT_W'(cnt); cfg_single = single;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle(string tag);
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    chk(tag, "run ended", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg_single = 1'b0;
    cfg_row_a = '0; cfg_row_b = '0; cfg_bank = '0; cfg_col = '0; cfg_count = '0;
    rd_ready = 1'b1; rdata_valid = 1'b0;
    hold_ret = 1'b0; lat = 3; ready_mode = 0; lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset",        busy,        0);
    chk("R1", "done in reset",        done,        0);
    chk("R1", "refresh_off in reset", refresh_off, 0);
    chk("R1", "rd_valid in reset",    rd_valid,    0);
    chk("R1", "toggles in reset",     toggles,     0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "busy after reset", busy, 0);

    // Adjacent pair, always ready.
    setup(6, 7, 5, 512, 20, 1'b0);
    pulse_start();
    chk("R2", "busy after start",   busy,        1);
    chk("R2", "refresh_off raised", refresh_off, 1);
    chk("R2", "done cleared",       done,        0);
    chk("R3", "first address",      longint'(rd_addr), 54784);
    wait_idle("R8");
    chk("R8", "toggles at end",     toggles,     20);
    chk("R8", "done at end",        done,        1);
    chk("R8", "refresh released",   refresh_off, 0);

    // Gap-of-one pair, initial stall then random ready.
    ready_mode = 2; lat = 5;
    setup(10, 12, 2, 512, 37, 1'b0);
    pulse_start();
    repeat (6) @(negedge clk);
    chk("R6", "toggles while stalled",  toggles,  0);
    chk("R6", "valid held while stalled", rd_valid, 1);
    chk("R4", "row of stalled read", longint'(rd_addr[ADDR_W-1 -: ROW_W]), 10);
    ready_mode = 1;
    wait_idle("R8");
    chk("R8", "toggles gap pair", toggles, 37);

    // Single-row mode.
    begin
      int bad;
      bad = 0;
      lat = 2;
      setup(9, 300, 7, 100, 15, 1'b1);
      pulse_start();
      for (int i = 0; i < 5000 && busy; i++) begin
        if (rd_valid && rd_addr[ADDR_W-1 -: ROW_W] != ROW_W'(9)) bad++;
        @(negedge clk);
      end
      chk("R5", "reads off row A", bad, 0);
      chk("R5", "single-row toggles", toggles, 15);
    end

    // Credit limit with returns held, and start while busy.
    ready_mode = 0; lat = 1; hold_ret = 1'b1;
    setup(100, 102, 1, 512, 10, 1'b0);
    pulse_start();
    repeat (12) @(negedge clk);
    chk("R7", "toggles at credit limit", toggles, MAX_OUT);
    chk("R7", "valid low at limit",      rd_valid, 0);
    chk("R7", "still busy",              busy,     1);
    setup(3, 4, 0, 0, 2, 1'b1);
    pulse_start();
    repeat (2) @(negedge clk);
    chk("R10", "toggles after start while busy", toggles, MAX_OUT);
    chk("R10", "busy after start while busy",    busy,    1);
    hold_ret = 1'b0;
    wait_idle("R10");
    chk("R10", "count kept from first start", toggles, 10);

    // Sticky done, then a zero-length run.
    repeat (10) @(negedge clk);
    chk("R11", "done held while idle", done, 1);
    setup(1, 2, 3, 4, 0, 1'b0);
    pulse_start();
    chk("R11", "done cleared by start", done,     0);
    chk("R9",  "busy for zero count",   busy,     1);
    chk("R9",  "no read for zero count", rd_valid, 0);
    @(negedge clk);
    chk("R9",  "zero count finished",   busy,     0);
    chk("R9",  "zero count done",       done,     1);
    chk("R9",  "zero count toggles",    toggles,  0);

    repeat (3) @(negedge clk);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired: actual %0d expected %0d", 1, 0);
    summary();
  end
endmodule